// File: doc/BRIEF.md
# Indirect-access interrupt redirection registers

This block is the software-visible register file of an interrupt router. A processor reaches it through only two bus locations. A select register at offset 0 holds a register index. A data window at offset 16 reads or writes whichever register that index names. Behind the window are an identification register and a read-only version word. A second index mirrors the identification register. There is also a table of redirection entries, 64 bits each, which software reaches as a low half and a high half.

The block keeps two status bits of every entry under hardware control. These are the outstanding-interrupt flag and the in-flight flag. They are presented on reads and cannot be altered by writes. When an entry write alters a field that affects trigger-mode bookkeeping, the block pulses a recalculation request. After any entry write it checks whether the pin is now unmasked, still asserted and free of an outstanding interrupt. If all three hold, it issues a delivery request for that pin. Delivery, assertion counting and end-of-interrupt handling belong to neighbouring logic. That logic feeds this block's status and assertion inputs.

Top module: `irq_route_regs`

## Requirements
- R1: An access is accepted when `req_valid` and `req_ready` are both high. The response (`rsp_valid`) appears in the following cycle. `req_ready` is low while a response is shown. Only accesses with `req_bytes` = 4 at offset 0 or 16 are legal. Any other access returns `rsp_err` = 1 and `rsp_rdata` = 0, and it changes no state.
- R2: A write at offset 0 stores all 32 bits into the select register, and a read at offset 0 returns it. Only bits 7:0 of the select register form the window index.
- R3: A window write to index 0 keeps only data bits 31:24 as the identifier. Window reads of index 0 and of index 2 both return the identifier in bits 31:24, with zeros below. Window writes to indices 1 and 2 change nothing.
- R4: A window read of index 1 returns 0x001F0011. Bits 23:16 hold the highest entry number (31) and bits 7:0 hold the version 0x11.
- R5: Entry n sits at window index 0x10+2n for bits 31:0 and at 0x11+2n for bits 63:32, for n from 0 to 31. A read returns the value last written.
- R6: After reset, both halves of every entry read 0x00010000 while the status inputs are low. Bit 16 of the low half is the mask, so every pin starts masked.
- R7: Bit 14 of an entry's low half reads `irr_status[n]`, and bit 12 reads `busy_status[n]`. Writing those bit positions has no effect on them.
- R8: `tmr_recalc` pulses for one cycle, together with the response, when an entry write changes any bit other than bit 16 (mask) or bit 13 (polarity). A write that alters only those two bits, or alters nothing, gives no pulse.
- R9: `deliver_valid` pulses for one cycle with the response after a write to either half of entry n, when three conditions hold after the write. Low-half bit 16 is 0, `irr_status[n]` is 0, and `pin_asserted[n]` is 1. `deliver_pin` then equals n.
- R10: Window indices 3 to 0x0F and 0x50 to 0xFF read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| irr_status | input | 32 | Per-pin outstanding-interrupt flag |
| busy_status | input | 32 | Per-pin in-flight flag |
| pin_asserted | input | 32 | Per-pin assertion count is positive |
| tmr_recalc | output | 1 | Trigger-mode recalculation request |
| deliver_valid | output | 1 | Delivery request |
| deliver_pin | output | 5 | Pin of the delivery request |

## Verification
Entry writes are tried in three forms: writes that change only the mask, only the polarity or nothing at all, and writes that change the vector or the destination. This separates the field-filtered recalculation pulse from a plain write strobe. Delivery is tried with the pin masked, with the outstanding flag set, with the pin deasserted, and through a high-half write. Each case blocks one condition of the delivery test on its own. Writes carrying ones in the status positions, and reads under raised status inputs, show that those bits follow hardware alone. Illegal sizes and offsets, and unused indices, are each followed by read-back to prove that nothing moved.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int IDX_W = 8;
    localparam logic [IDX_W-1:0] IDX_ID  = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VER = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ARB = 8'h02;
    localparam logic [IDX_W-1:0] IDX_TBL = 8'h10;
    localparam logic [7:0]       VERSION = 8'h11;
    localparam int B_MASK = 16;
    localparam int B_IRR  = 14;
    localparam int B_POL  = 13;
    localparam int B_BUSY = 12;
    localparam logic [31:0] RO_BITS    = (32'd1 << B_IRR) | (32'd1 << B_BUSY);
    localparam logic [63:0] NO_RECALC  = (64'd1 << B_MASK) | (64'd1 << B_POL);
    localparam logic [31:0] RESET_HALF = 32'h0001_0000;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_WIN,
        ACC_BAD
    } acc_kind_e;
endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SEL_OFS = 0,
    parameter int WIN_OFS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_bytes,
    input  logic [31:0]       req_wdata,
    output acc_kind_e         kind,
    output logic [31:0]       sel_word
);
    logic [31:0] sel_d, sel_q;

    always_comb begin
        if (req_bytes != 4'd4)
            kind = ACC_BAD;
        else if (req_addr == ADDR_W'(SEL_OFS))
            kind = ACC_SEL;
        else if (req_addr == ADDR_W'(WIN_OFS))
            kind = ACC_WIN;
        else
            kind = ACC_BAD;
        sel_d = sel_q;
        if (acc && req_write && kind == ACC_SEL)
            sel_d = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_word = sel_q;

    // R2: the select register moves only on an accepted access
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(sel_word));
endmodule

// File: rtl/irq_entry_table.sv
module irq_entry_table
    import irq_route_pkg::*;
#(
    parameter int N_ENT = 32,
    localparam int PIN_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PIN_W-1:0] pin,
    input  logic             hi_half,
    input  logic [31:0]      wdata,
    input  logic [N_ENT-1:0] irr_status,
    input  logic [N_ENT-1:0] busy_status,
    input  logic [N_ENT-1:0] pin_asserted,
    output logic [31:0]      rd_data,
    output logic             recalc,
    output logic             dlv
);
    typedef struct packed {
        logic [N_ENT-1:0][31:0] lo;
        logic [N_ENT-1:0][31:0] hi;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [N_ENT-1:0][31:0] lo_view;
    logic [63:0] old_e, new_e;

    for (genvar g = 0; g < N_ENT; g++) begin : g_view
        assign lo_view[g] = tbl_q.lo[g]
                          | (32'(irr_status[g])  << B_IRR)
                          | (32'(busy_status[g]) << B_BUSY);
    end

    always_comb begin
        tbl_d = tbl_q;
        old_e = {tbl_q.hi[pin], tbl_q.lo[pin]};
        new_e = old_e;
        if (hi_half) new_e[63:32] = wdata;
        else         new_e[31:0]  = wdata & ~RO_BITS;
        if (wr_en) begin
            tbl_d.lo[pin] = new_e[31:0];
            tbl_d.hi[pin] = new_e[63:32];
        end
        recalc  = wr_en && (((old_e ^ new_e) & ~NO_RECALC) != 64'd0);
        dlv     = wr_en && !new_e[B_MASK] && !irr_status[pin] && pin_asserted[pin];
        rd_data = hi_half ? tbl_q.hi[pin] : lo_view[pin];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q.lo <= {N_ENT{RESET_HALF}};
            tbl_q.hi <= {N_ENT{RESET_HALF}};
        end else begin
            tbl_q <= tbl_d;
        end
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int N_ENT  = 32,
    parameter int ADDR_W = 8,
    localparam int PIN_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_bytes,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    input  logic [N_ENT-1:0]  irr_status,
    input  logic [N_ENT-1:0]  busy_status,
    input  logic [N_ENT-1:0]  pin_asserted,
    output logic              tmr_recalc,
    output logic              deliver_valid,
    output logic [PIN_W-1:0]  deliver_pin
);
    localparam logic [31:0] VER_WORD = (32'(N_ENT - 1) << 16) | 32'(VERSION);
    localparam int TBL_END = int'(IDX_TBL) + 2 * N_ENT;

    typedef struct packed {
        logic [7:0]       id;
        logic             rsp_v;
        logic             err;
        logic [31:0]      rdata;
        logic             recalc;
        logic             dlv;
        logic [PIN_W-1:0] dlv_pin;
    } st_t;

    st_t st_d, st_q;
    acc_kind_e kind;
    logic [31:0] sel_word, tbl_rd;
    logic [IDX_W-1:0] idx, ent_off;
    logic [PIN_W-1:0] ent_pin;
    logic acc, is_ent, tbl_wr, tbl_recalc, tbl_dlv;

    assign req_ready = !st_q.rsp_v;
    assign acc       = req_valid && req_ready;
    assign idx       = sel_word[IDX_W-1:0];
    assign is_ent    = (int'(idx) >= int'(IDX_TBL)) && (int'(idx) < TBL_END);
    assign ent_off   = idx - IDX_TBL;
    assign ent_pin   = PIN_W'(ent_off >> 1);
    assign tbl_wr    = acc && kind == ACC_WIN && req_write && is_ent;

    irq_win_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk(clk), .rst_n(rst_n), .acc(acc), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .kind(kind), .sel_word(sel_word)
    );

    irq_entry_table #(.N_ENT(N_ENT)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .pin(ent_pin),
        .hi_half(ent_off[0]), .wdata(req_wdata), .irr_status(irr_status),
        .busy_status(busy_status), .pin_asserted(pin_asserted),
        .rd_data(tbl_rd), .recalc(tbl_recalc), .dlv(tbl_dlv)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsp_v   = acc;
        st_d.err     = 1'b0;
        st_d.rdata   = '0;
        st_d.recalc  = 1'b0;
        st_d.dlv     = 1'b0;
        st_d.dlv_pin = '0;
        if (acc) begin
            unique case (kind)
                ACC_BAD: st_d.err = 1'b1;
                ACC_SEL: if (!req_write) st_d.rdata = sel_word;
                ACC_WIN: begin
                    if (req_write) begin
                        if (idx == IDX_ID) st_d.id = req_wdata[31:24];
                        st_d.recalc  = tbl_recalc;
                        st_d.dlv     = tbl_dlv;
                        st_d.dlv_pin = ent_pin;
                    end else if (idx == IDX_ID || idx == IDX_ARB) begin
                        st_d.rdata = {st_q.id, 24'h0};
                    end else if (idx == IDX_VER) begin
                        st_d.rdata = VER_WORD;
                    end else if (is_ent) begin
                        st_d.rdata = tbl_rd;
                    end
                end
                default: st_d.err = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid     = st_q.rsp_v;
    assign rsp_err       = st_q.err;
    assign rsp_rdata     = st_q.rdata;
    assign tmr_recalc    = st_q.recalc;
    assign deliver_valid = st_q.dlv;
    assign deliver_pin   = st_q.dlv_pin;

    // R1: no new access while a response is shown
    p_ready_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    // R1: a wrong size is answered with an error
    p_bad_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_bytes != 4'd4) |=> (rsp_valid && rsp_err));
    // R8: recalculation only follows an accepted write
    p_recalc_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_recalc |-> $past(req_valid && req_ready && req_write));
    // R9: delivery only rides on a successful response
    p_dlv_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> (rsp_valid && !rsp_err));
endmodule

// File: tb/test_irq_route_regs.sv
`timescale 1ns/100ps
module test_irq_route_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_bytes = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, tmr_recalc, deliver_valid;
    logic [31:0] rsp_rdata;
    logic [4:0]  deliver_pin;
    logic [31:0] irr = '0, busy = '0, asrt = '0;

    int n_cmp = 0, n_bad = 0;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic        recalc;
        logic        dlv;
        logic [4:0]  pin;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_sel = '0;
    logic [7:0]  m_id = '0;
    logic [31:0] m_lo [32];
    logic [31:0] m_hi [32];

    always #2.5 clk = ~clk;

    irq_route_regs i_irq_route_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_bytes(req_bytes),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .irr_status(irr), .busy_status(busy),
        .pin_asserted(asrt), .tmr_recalc(tmr_recalc),
        .deliver_valid(deliver_valid), .deliver_pin(deliver_pin)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pop expected items as responses appear
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected response", 32'(rsp_valid), 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_rdata === e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
                check(rsp_err === e.err, e.tag, "err", 32'(rsp_err), 32'(e.err));
                check(tmr_recalc === e.recalc, e.tag, "recalc",
                      32'(tmr_recalc), 32'(e.recalc));
                check(deliver_valid === e.dlv, e.tag, "deliver",
                      32'(deliver_valid), 32'(e.dlv));
                if (e.dlv)
                    check(deliver_pin === e.pin, e.tag, "deliver_pin",
                          32'(deliver_pin), 32'(e.pin));
            end
        end else if (rst_n && (tmr_recalc || deliver_valid)) begin
            check(1'b0, "R8", "pulse without response",
                  32'({tmr_recalc, deliver_valid}), 32'h0);
        end
    end

    // driver: compute the expected response, queue it, run the access
    task automatic access(input logic wr, input logic [7:0] addr,
                          input logic [3:0] nbytes, input logic [31:0] data,
                          input string tag);
        exp_t e;
        logic [7:0] idx;
        logic [63:0] old_e, new_e;
        int p;
        bit ent;
        e.rdata = '0; e.err = 1'b0; e.recalc = 1'b0; e.dlv = 1'b0; e.pin = '0;
        e.tag = tag;
        idx = m_sel[7:0];
        ent = (idx >= 8'h10) && (idx < 8'h50);
        p   = (int'(idx) - 16) / 2;
        if (nbytes != 4'd4 || (addr != 8'd0 && addr != 8'd16)) begin
            e.err = 1'b1;
        end else if (addr == 8'd0) begin
            if (wr) m_sel = data;
            else    e.rdata = m_sel;
        end else if (wr) begin
            if (idx == 8'h00) m_id = data[31:24];
            if (ent) begin
                old_e = {m_hi[p], m_lo[p]};
                new_e = old_e;
                if (idx[0]) new_e[63:32] = data;
                else        new_e[31:0]  = data & ~32'h0000_5000;
                m_hi[p]  = new_e[63:32];
                m_lo[p]  = new_e[31:0];
                e.recalc = (((old_e ^ new_e) & ~64'h0001_2000) != 0);
                e.dlv    = !new_e[16] && !irr[p] && asrt[p];
                e.pin    = 5'(p);
            end
        end else begin
            if (idx == 8'h00 || idx == 8'h02) e.rdata = {m_id, 24'h0};
            else if (idx == 8'h01)            e.rdata = 32'h001F_0011;
            else if (ent)
                e.rdata = idx[0] ? m_hi[p]
                                 : (m_lo[p] | (32'(irr[p]) << 14) | (32'(busy[p]) << 12));
        end
        sb.push_back(e);
        check(req_ready === 1'b1, "R1", "ready before access", 32'(req_ready), 32'h1);
        req_valid = 1'b1; req_write = wr; req_addr = addr;
        req_bytes = nbytes; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic sel(input logic [31:0] v, input string tag);
        access(1'b1, 8'd0, 4'd4, v, tag);
    endtask
    task automatic win_wr(input logic [31:0] v, input string tag);
        access(1'b1, 8'd16, 4'd4, v, tag);
    endtask
    task automatic win_rd(input string tag);
        access(1'b0, 8'd16, 4'd4, 32'h0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_lo[i] = 32'h0001_0000;
            m_hi[i] = 32'h0001_0000;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R6: reset state at the ports
        check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        check(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
        check(tmr_recalc === 1'b0 && deliver_valid === 1'b0, "R8", "pulses after reset",
              32'({tmr_recalc, deliver_valid}), 32'h0);

        // R2: select register read-back, index from low byte
        sel(32'h1234_5601, "R2");
        access(1'b0, 8'd0, 4'd4, 32'h0, "R2");
        win_rd("R4");                       // index 0x01 -> version word
        sel(32'h0000_AB01, "R2");
        win_rd("R4");

        // R3: identifier
        sel(32'h0, "R3");
        win_wr(32'hDEAD_BEEF, "R3");
        win_rd("R3");
        sel(32'h2, "R3");
        win_rd("R3");
        win_wr(32'h1100_0000, "R3");
        sel(32'h0, "R3");
        win_rd("R3");
        sel(32'h1, "R3");
        win_wr(32'hFFFF_FFFF, "R3");
        win_rd("R4");

        // R6: reset value of entries
        sel(32'h10, "R6"); win_rd("R6");
        sel(32'h4F, "R6"); win_rd("R6");

        // R5 / R8: entry 5 low half is index 0x1A
        sel(32'h1A, "R5");
        win_wr(32'h0001_8030, "R8");         // vector + trigger change, masked
        win_rd("R5");
        win_wr(32'h0000_8030, "R8");         // mask only, pin idle
        win_wr(32'h0000_A030, "R8");         // polarity only
        win_wr(32'h0000_A030, "R8");         // no change
        win_rd("R5");

        // R9: delivery through a high-half write
        asrt[5] = 1'b1;
        sel(32'h1B, "R9");
        win_wr(32'hFF00_0000, "R9");
        win_rd("R5");

        // R7 / R9: outstanding flag blocks delivery, status bits read-only
        irr[5] = 1'b1;
        sel(32'h1A, "R9");
        win_wr(32'h0000_A030, "R9");
        win_rd("R7");
        irr[5] = 1'b0;
        win_wr(32'h0000_F030, "R7");         // ones in status positions
        win_rd("R7");
        busy[5] = 1'b1;
        win_rd("R7");
        busy[5] = 1'b0;
        win_wr(32'h0001_A030, "R9");         // masked while asserted
        win_rd("R5");

        // R9: entry 31 low half, index 0x4E
        asrt[31] = 1'b1;
        sel(32'h4E, "R9");
        win_wr(32'h0000_0041, "R9");
        win_rd("R5");

        // R10: unused indices
        sel(32'h05, "R10"); win_rd("R10"); win_wr(32'h5555_5555, "R10"); win_rd("R10");
        sel(32'h50, "R10"); win_rd("R10"); win_wr(32'hAAAA_AAAA, "R10"); win_rd("R10");
        sel(32'hFF, "R10"); win_rd("R10");
        sel(32'h0, "R10");  win_rd("R10");
        sel(32'h4F, "R10"); win_rd("R10");

        // R1: illegal accesses change nothing
        sel(32'h1A, "R1");
        access(1'b1, 8'd16, 4'd2, 32'h0000_0000, "R1");
        access(1'b1, 8'd16, 4'd1, 32'h0000_0000, "R1");
        access(1'b1, 8'd4,  4'd4, 32'h0000_0000, "R1");
        access(1'b0, 8'd8,  4'd4, 32'h0, "R1");
        access(1'b1, 8'd0,  4'd8, 32'h0000_0010, "R1");
        access(1'b0, 8'd0,  4'd4, 32'h0, "R1");
        win_rd("R1");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R1", "responses outstanding", 32'(sb.size()), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule